// File: doc/BRIEF.md
# Early Control-Flow Redirect with Epoch Tagging

This block owns the fetch address and the two epoch bits of a six-stage in-order pipeline (fetch, decode, register read, execute, memory, writeback). Fetch issues one address per accepted cycle. It guesses that the next address is the current one plus four. Each fetched instruction leaves with that guess and with the current values of both epoch bits. Three later stages can resolve control flow. Decode handles absolute jumps, register read handles register-indirect jumps, and execute handles conditional branches. Each of these stages reports its computed next address and the tags the instruction carries.

A resolving stage first checks the instruction's tags. If they are stale, the stage marks the instruction poisoned. The instruction is not dropped: it travels on down the pipe and is discarded at writeback. If the tags are good and the computed address differs from the guess, the stage steers fetch straight to the computed address and flips an epoch bit. Decode and register read flip the front epoch. Execute flips the back epoch. When several stages redirect in the same cycle, the oldest instruction (the latest stage) wins, and the younger instructions in front of it are poisoned. The memory and writeback stages do not check epochs. They only turn the poison mark into enables for the data memory write and the register write.

Top module: `pc_epoch_redirect`

## Requirements
- R1: While reset is asserted and until the first clock edge after its release, fetch presents address 0x0000_0000 with both epoch tags 0 and its valid output low. Valid rises on the first edge after reset is released, and the address is not advanced on that edge.
- R2: With fetch valid, ready high and no redirect, the fetch address advances by 4 each cycle, and the predicted next address output always equals the fetch address plus 4.
- R3: With ready low and no redirect, the fetch address and both epoch tags hold their values.
- R4: A non-poisoned decode instruction whose tags match both epochs, and that is marked as resolved with a computed address different from its predicted address, requests a redirect. On that edge the fetch address becomes the computed address and the front epoch flips.
- R5: A register-read redirect works the same way and also flips the front epoch. Register read compares only the back epoch tag and ignores the front epoch tag.
- R6: An execute redirect loads the computed address and flips the back epoch, leaving the front epoch unchanged. Execute compares only the back epoch tag.
- R7: A resolved instruction whose computed address equals its predicted address requests no redirect.
- R8: The redirect output is at most one-hot, bit 0 for decode, bit 1 for register read, bit 2 for execute. The latest requesting stage wins, and every valid instruction in an earlier stage is reported poisoned in that cycle.
- R9: A valid instruction whose checked tags differ from the current epochs is reported poisoned and requests no redirect.
- R10: A valid instruction that arrives already poisoned stays poisoned and requests no redirect. It leaves the PC and both epochs as they would be without it.
- R11: The memory enable is high only for a valid, non-poisoned memory-stage instruction. The writeback commit is high only for a valid, non-poisoned writeback instruction.
- R12: A redirect takes effect even while ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_rdy | input | 1 | Fetch output queue can accept |
| f_vld | output | 1 | Fetch address is valid |
| f_pc | output | XLEN | Fetch address |
| f_ppc | output | XLEN | Predicted next address (fetch address + 4) |
| f_dtag | output | 1 | Front epoch stamped on the fetched instruction |
| f_etag | output | 1 | Back epoch stamped on the fetched instruction |
| s_vld | input | 3 | Stage holds an instruction (0 decode, 1 register read, 2 execute) |
| s_psn | input | 3 | Incoming poison mark per stage |
| s_dtag | input | 3 | Front epoch tag carried per stage |
| s_etag | input | 3 | Back epoch tag carried per stage |
| s_res | input | 3 | Instruction resolves its control flow in this stage |
| s_ppc | input | 3 x XLEN | Predicted next address carried per stage |
| s_npc | input | 3 x XLEN | Computed next address per stage |
| s_kill | output | 3 | Poison mark to pass to the next stage |
| s_redir | output | 3 | Winning redirect, one-hot or zero |
| m_vld | input | 1 | Memory stage holds an instruction |
| m_psn | input | 1 | Memory stage instruction is poisoned |
| m_act | output | 1 | Data memory access permitted |
| w_vld | input | 1 | Writeback holds an instruction |
| w_psn | input | 1 | Writeback instruction is poisoned |
| w_commit | output | 1 | Register write permitted |

## Verification
The bench goes after same-cycle collisions between stages. A wrong priority would steer fetch to a younger instruction's target, and a missing younger-kill would let a wrong-path jump reach register read unmarked. It feeds stale tags to each stage, including a stale front tag at register read. A design that checked the wrong epoch there would either drop a correct redirect or obey a wrong-path one. It also combines a redirect with a stalled fetch queue, where a design that gates redirects on ready would keep fetching the wrong path. Finally, it sends poisoned instructions into execute, memory and writeback, where leaking the mark would flip an epoch or commit a killed result.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
   localparam int NSTG = 3;
   typedef enum int {
      STG_DEC = 0,
      STG_RRD = 1,
      STG_EXE = 2
   } stg_e;
endpackage

// File: rtl/rdr_stage_chk.sv
module rdr_stage_chk #(
   parameter int W       = 32,
   parameter bit CHK_DEP = 1'b0
) (
   input  logic         vld,
   input  logic         psn,
   input  logic         dtag,
   input  logic         etag,
   input  logic         cur_d,
   input  logic         cur_e,
   input  logic         res,
   input  logic [W-1:0] npc,
   input  logic [W-1:0] ppc,
   input  logic         kill_yng,
   output logic         want,
   output logic         kill
);
   logic stale;

   generate
      if (CHK_DEP) begin : g_both
         assign stale = (dtag != cur_d) || (etag != cur_e);
      end else begin : g_back
         assign stale = (etag != cur_e);
      end
   endgenerate

   assign want = vld && !psn && !stale && res && (npc != ppc);
   assign kill = vld && (psn || stale || kill_yng);
endmodule

// File: rtl/rdr_arb.sv
module rdr_arb #(
   parameter int W = 32,
   parameter int N = 3
) (
   input  logic [N-1:0]        want,
   input  logic [N-1:0][W-1:0] tgt,
   output logic [N-1:0]        grant,
   output logic [N-1:0]        yng,
   output logic                any,
   output logic [W-1:0]        sel
);
   generate
      if (N < 1) begin : g_bad_n
         $error("rdr_arb: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_pri
         if (i == N - 1) begin : g_top
            assign yng[i] = 1'b0;
         end else begin : g_low
            assign yng[i] = |want[N-1:i+1];
         end
         assign grant[i] = want[i] && !yng[i];
      end
   endgenerate

   assign any = |want;

   always_comb begin
      sel = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) sel = tgt[i];
      end
   end
endmodule

// File: rtl/rdr_fetch.sv
module rdr_fetch #(
   parameter int          W      = 32,
   parameter logic [W-1:0] RST_PC = '0,
   parameter int          STEP   = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rdy,
   input  logic         any,
   input  logic         dflip,
   input  logic         eflip,
   input  logic [W-1:0] tgt,
   output logic         vld,
   output logic [W-1:0] pc,
   output logic [W-1:0] ppc,
   output logic         dep,
   output logic         eep
);
   localparam logic [W-1:0] INC = W'(STEP);

   logic         run_q;
   logic [W-1:0] pc_q;
   logic         dep_q, eep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         pc_q  <= RST_PC;
         dep_q <= 1'b0;
         eep_q <= 1'b0;
      end else begin
         run_q <= 1'b1;
         if (any) begin
            pc_q  <= tgt;
            dep_q <= dep_q ^ dflip;
            eep_q <= eep_q ^ eflip;
         end else if (run_q && rdy) begin
            pc_q <= pc_q + INC;
         end
      end
   end

   assign vld = run_q;
   assign pc  = pc_q;
   assign ppc = pc_q + INC;
   assign dep = dep_q;
   assign eep = eep_q;

   p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy && !any) |=> ($stable(pc) && $stable(dep) && $stable(eep)));
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && rdy && !any) |=> (pc == $past(pc) + INC));
   p_redir_pc_r12: assert property (@(posedge clk) disable iff (!rst_n)
      any |=> (pc == $past(tgt)));
endmodule

// File: rtl/pc_epoch_redirect.sv
module pc_epoch_redirect
   import rdr_pkg::*;
#(
   parameter int           XLEN   = 32,
   parameter logic [XLEN-1:0] RST_PC = '0,
   parameter int           STEP   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        f_rdy,
   output logic                        f_vld,
   output logic [XLEN-1:0]             f_pc,
   output logic [XLEN-1:0]             f_ppc,
   output logic                        f_dtag,
   output logic                        f_etag,
   input  logic [NSTG-1:0]             s_vld,
   input  logic [NSTG-1:0]             s_psn,
   input  logic [NSTG-1:0]             s_dtag,
   input  logic [NSTG-1:0]             s_etag,
   input  logic [NSTG-1:0]             s_res,
   input  logic [NSTG-1:0][XLEN-1:0]   s_ppc,
   input  logic [NSTG-1:0][XLEN-1:0]   s_npc,
   output logic [NSTG-1:0]             s_kill,
   output logic [NSTG-1:0]             s_redir,
   input  logic                        m_vld,
   input  logic                        m_psn,
   output logic                        m_act,
   input  logic                        w_vld,
   input  logic                        w_psn,
   output logic                        w_commit
);
   generate
      if (XLEN < 8) begin : g_bad_xlen
         $error("pc_epoch_redirect: XLEN too small");
      end
      if (STEP <= 0) begin : g_bad_step
         $error("pc_epoch_redirect: STEP must be positive");
      end
   endgenerate

   logic [NSTG-1:0] want, yng, grant;
   logic            any;
   logic [XLEN-1:0] tgt;
   logic            dflip, eflip;

   generate
      for (genvar i = 0; i < NSTG; i++) begin : g_stg
         rdr_stage_chk #(
            .W       (XLEN),
            .CHK_DEP (i == int'(STG_DEC))
         ) u_chk (
            .vld      (s_vld[i]),
            .psn      (s_psn[i]),
            .dtag     (s_dtag[i]),
            .etag     (s_etag[i]),
            .cur_d    (f_dtag),
            .cur_e    (f_etag),
            .res      (s_res[i]),
            .npc      (s_npc[i]),
            .ppc      (s_ppc[i]),
            .kill_yng (yng[i]),
            .want     (want[i]),
            .kill     (s_kill[i])
         );
      end
   endgenerate

   rdr_arb #(.W(XLEN), .N(NSTG)) u_arb (
      .want  (want),
      .tgt   (s_npc),
      .grant (grant),
      .yng   (yng),
      .any   (any),
      .sel   (tgt)
   );

   assign dflip = grant[STG_DEC] || grant[STG_RRD];
   assign eflip = grant[STG_EXE];

   rdr_fetch #(.W(XLEN), .RST_PC(RST_PC), .STEP(STEP)) u_fetch (
      .clk   (clk),
      .rst_n (rst_n),
      .rdy   (f_rdy),
      .any   (any),
      .dflip (dflip),
      .eflip (eflip),
      .tgt   (tgt),
      .vld   (f_vld),
      .pc    (f_pc),
      .ppc   (f_ppc),
      .dep   (f_dtag),
      .eep   (f_etag)
   );

   assign s_redir  = grant;
   assign m_act    = m_vld && !m_psn;
   assign w_commit = w_vld && !w_psn;

   p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(s_redir));
   p_exe_epoch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      s_redir[STG_EXE] |=> (f_etag != $past(f_etag)) && (f_dtag == $past(f_dtag)));
   p_front_epoch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (s_redir[STG_DEC] || s_redir[STG_RRD]) |=>
         (f_dtag != $past(f_dtag)) && (f_etag == $past(f_etag)));
   p_psn_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (s_vld[STG_EXE] && s_psn[STG_EXE]) |-> (s_kill[STG_EXE] && !s_redir[STG_EXE]));
   p_no_wrong_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (w_commit || m_act) |-> !((w_commit && w_psn) || (m_act && m_psn)));
endmodule

// File: tb/sim_pc_epoch_redirect.sv
module sim_pc_epoch_redirect;
   localparam int CLK_P = 10;
   localparam int XL    = 32;

   typedef struct packed {
      logic       rdy;
      logic [2:0] vld;
      logic [2:0] psn;
      logic [2:0] dok;
      logic [2:0] eok;
      logic [2:0] res;
      logic [2:0] miss;
      logic [2:0] xr;
      logic [2:0] xk;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 3'b000, 3'b000, 3'b111, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000},
      '{1'b0, 3'b000, 3'b000, 3'b111, 3'b111, 3'b000, 3'b000, 3'b000, 3'b000},
      '{1'b1, 3'b001, 3'b000, 3'b111, 3'b111, 3'b001, 3'b001, 3'b001, 3'b000},
      '{1'b1, 3'b001, 3'b000, 3'b111, 3'b111, 3'b001, 3'b000, 3'b000, 3'b000},
      '{1'b1, 3'b001, 3'b000, 3'b110, 3'b111, 3'b001, 3'b001, 3'b000, 3'b001},
      '{1'b1, 3'b010, 3'b000, 3'b101, 3'b111, 3'b010, 3'b010, 3'b010, 3'b000},
      '{1'b1, 3'b100, 3'b000, 3'b111, 3'b111, 3'b100, 3'b100, 3'b100, 3'b000},
      '{1'b1, 3'b111, 3'b000, 3'b111, 3'b111, 3'b111, 3'b111, 3'b100, 3'b011},
      '{1'b0, 3'b011, 3'b000, 3'b111, 3'b111, 3'b011, 3'b011, 3'b010, 3'b001},
      '{1'b1, 3'b100, 3'b100, 3'b111, 3'b111, 3'b100, 3'b100, 3'b000, 3'b100},
      '{1'b1, 3'b010, 3'b000, 3'b111, 3'b101, 3'b010, 3'b010, 3'b000, 3'b010},
      '{1'b1, 3'b101, 3'b000, 3'b111, 3'b111, 3'b101, 3'b001, 3'b001, 3'b000},
      '{1'b1, 3'b101, 3'b000, 3'b111, 3'b011, 3'b101, 3'b101, 3'b001, 3'b100},
      '{1'b1, 3'b001, 3'b001, 3'b111, 3'b111, 3'b001, 3'b001, 3'b000, 3'b001}
   };

   function automatic string tag_of(int k);
      case (k)
         0:  return "R2";
         1:  return "R3";
         2:  return "R4";
         3:  return "R7";
         4:  return "R9";
         5:  return "R5";
         6:  return "R6";
         7:  return "R8";
         8:  return "R12";
         9:  return "R10";
         10: return "R9";
         11: return "R7";
         12: return "R9";
         default: return "R10";
      endcase
   endfunction

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                f_rdy = 1'b0;
   logic                f_vld;
   logic [XL-1:0]       f_pc, f_ppc;
   logic                f_dtag, f_etag;
   logic [2:0]          s_vld = '0, s_psn = '0, s_dtag = '0, s_etag = '0, s_res = '0;
   logic [2:0][XL-1:0]  s_ppc = '0, s_npc = '0;
   logic [2:0]          s_kill, s_redir;
   logic                m_vld = 1'b0, m_psn = 1'b0, m_act;
   logic                w_vld = 1'b0, w_psn = 1'b0, w_commit;

   int n_run = 0;
   int n_bad = 0;

   always #(CLK_P / 2) clk = ~clk;

   pc_epoch_redirect u0 (
      .clk(clk), .rst_n(rst_n), .f_rdy(f_rdy), .f_vld(f_vld), .f_pc(f_pc),
      .f_ppc(f_ppc), .f_dtag(f_dtag), .f_etag(f_etag), .s_vld(s_vld),
      .s_psn(s_psn), .s_dtag(s_dtag), .s_etag(s_etag), .s_res(s_res),
      .s_ppc(s_ppc), .s_npc(s_npc), .s_kill(s_kill), .s_redir(s_redir),
      .m_vld(m_vld), .m_psn(m_psn), .m_act(m_act), .w_vld(w_vld),
      .w_psn(w_psn), .w_commit(w_commit)
   );

   task automatic chk(input logic ok, input string req, input logic [XL-1:0] act,
                      input logic [XL-1:0] exp);
      n_run++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin : main
      logic          md, me;
      logic [XL-1:0] mpc;
      logic [XL-1:0] exp_t;

      repeat (3) @(negedge clk);
      chk(f_vld == 1'b0, "R1 vld in reset", XL'(f_vld), 0);
      chk(f_pc == '0, "R1 pc in reset", f_pc, 0);
      chk({f_dtag, f_etag} == 2'b00, "R1 tags in reset", XL'({f_dtag, f_etag}), 0);
      rst_n = 1'b1;
      f_rdy = 1'b1;
      #1;
      chk(f_vld == 1'b0, "R1 vld before first edge", XL'(f_vld), 0);
      @(negedge clk);
      chk(f_vld == 1'b1, "R1 vld after first edge", XL'(f_vld), 1);
      chk(f_pc == '0, "R1 pc not advanced on first edge", f_pc, 0);
      chk(f_ppc == f_pc + 4, "R2 predicted next", f_ppc, f_pc + 4);

      md  = 1'b0;
      me  = 1'b0;
      mpc = '0;
      for (int k = 0; k < NV; k++) begin
         f_rdy = TBL[k].rdy;
         s_vld = TBL[k].vld;
         s_psn = TBL[k].psn;
         s_res = TBL[k].res;
         for (int i = 0; i < 3; i++) begin
            s_dtag[i] = TBL[k].dok[i] ? md : ~md;
            s_etag[i] = TBL[k].eok[i] ? me : ~me;
            s_ppc[i]  = 32'h800 + XL'(4 * i);
            s_npc[i]  = TBL[k].miss[i] ? 32'h1000 + XL'(64 * k) + XL'(4 * i) : s_ppc[i];
         end
         #2;
         chk(s_redir == TBL[k].xr, $sformatf("%s redirect vec %0d", tag_of(k), k),
             XL'(s_redir), XL'(TBL[k].xr));
         chk(s_kill == TBL[k].xk, $sformatf("%s poison vec %0d", tag_of(k), k),
             XL'(s_kill), XL'(TBL[k].xk));
         if (TBL[k].xr != 3'b000) begin
            for (int i = 0; i < 3; i++) begin
               if (TBL[k].xr[i]) begin
                  mpc = s_npc[i];
                  if (i == 2) me = ~me;
                  else        md = ~md;
               end
            end
         end else if (TBL[k].rdy) begin
            mpc = mpc + 4;
         end
         exp_t = XL'({md, me});
         @(negedge clk);
         chk(f_pc == mpc, $sformatf("%s fetch pc vec %0d", tag_of(k), k), f_pc, mpc);
         chk({f_dtag, f_etag} == exp_t[1:0],
             $sformatf("%s epochs vec %0d", tag_of(k), k), XL'({f_dtag, f_etag}), exp_t);
         chk(f_ppc == f_pc + 4, "R2 predicted next follows pc", f_ppc, f_pc + 4);
      end

      s_vld = '0;
      s_psn = '0;
      s_res = '0;
      m_vld = 1'b1; m_psn = 1'b0; w_vld = 1'b1; w_psn = 1'b0;
      #1;
      chk(m_act == 1'b1, "R11 memory enable clean", XL'(m_act), 1);
      chk(w_commit == 1'b1, "R11 commit clean", XL'(w_commit), 1);
      m_psn = 1'b1; w_psn = 1'b1;
      #1;
      chk(m_act == 1'b0, "R11 memory enable poisoned", XL'(m_act), 0);
      chk(w_commit == 1'b0, "R11 commit poisoned", XL'(w_commit), 0);
      m_vld = 1'b0; w_vld = 1'b0; m_psn = 1'b0; w_psn = 1'b0;
      #1;
      chk(m_act == 1'b0 && w_commit == 1'b0, "R11 idle", XL'({m_act, w_commit}), 0);

      f_rdy = 1'b0;
      mpc = f_pc;
      repeat (3) @(negedge clk);
      chk(f_pc == mpc, "R3 long stall holds pc", f_pc, mpc);
      f_rdy = 1'b1;
      @(negedge clk);
      chk(f_pc == mpc + 4, "R2 resume after stall", f_pc, mpc + 4);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule